// File: doc/BRIEF.md
# PRBS-Scrambled Link Demodulator

This receive-side block recovers a slow serial signal that was scrambled with a fast PRBS7 sequence so that a clock-recovering receiver sees frequent transitions. Each clock it consumes one 10-bit parallel word from the deserializer. The earliest bit is in the MSB.

After reset the line carries the bare PRBS. The block loads its local generator from the received bits. It then predicts every following bit and counts the bits that differ. It declares lock after an unbroken run of clean words. A control-side `data_mode` input then switches the block from checking to demodulation. In that mode each received bit is XORed with the local PRBS bit, which gives the oversampled slow stream. A majority-vote decimator folds every OSR demodulated words into one word of recovered symbols and marks it with a one-cycle valid strobe.

The sampling phase of the decimator is fixed. It restarts whenever demodulation stops.

Top module: `prbs_link_demod`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `locked` is 0, `err_count` is 0 and `data_valid` is 0. Reset is synchronous and active high.
- R2: The generator follows PRBS7, where b[n] = b[n-6] XOR b[n-7]. Words are taken MSB first. The first word after reset is a seed word: the generator is loaded with the seven most recent bits of that word, and no errors are counted on it.
- R3: `locked` rises after the 64th consecutive mismatch-free word that follows a seed. It is visible on the cycle after the clock edge that takes in that word, and not earlier.
- R4: While the block is training and not locked, a word that differs from the prediction does three things. It adds its number of mismatched bits to `err_count`, which saturates and never wraps. It restarts the clean run. It reseeds the generator from that same word.
- R5: `err_count` does not change while `locked` is 1. This includes the word that causes lock to drop.
- R6: While `locked` and `data_mode` are both 1, `locked` stays 1 whatever the line carries.
- R7: While `locked` is 1 and `data_mode` is 0, checking continues. A clean word keeps lock. A mismatching word clears `locked`, reseeds the generator and restarts training.
- R8: While `locked` and `data_mode` are both 1, each received bit is XORed with the local PRBS bit to form the demodulated sample stream.
- R9: Every OSR consecutive demodulated words (default 3) produce one `data_out` word with `data_valid` high for exactly one cycle, on the cycle after the last word of the group. Output bit W-1-k is the majority of samples k*OSR to k*OSR+OSR-1 of the group, with sample 0 being the MSB of the first word. A tie gives 0.
- R10: While `locked` or `data_mode` is 0, no demodulation takes place and `data_valid` stays 0. Each such cycle returns the decimator to the start of a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | W (10) | Received parallel word, earliest bit in the MSB |
| data_mode | input | 1 | 1 selects demodulation once locked; 0 selects checking |
| locked | output | 1 | Local generator is in step with the line |
| err_count | output | ERR_W (16) | Saturating count of mismatched bits seen while training |
| data_out | output | W (10) | Recovered low-rate symbols, earliest in the MSB |
| data_valid | output | 1 | One-cycle strobe marking a new `data_out` word |

## Verification
The assertions check several properties on every cycle:
- lock rises only at the end of a full clean run;
- a training mismatch restarts the run;
- the error count never decreases and stays fixed while locked;
- lock holds in data mode;
- the decimator strobes only after a complete group and clears its phase when demodulation stops.

Other behaviours can only be shown by the bench scenarios, because they depend on the bench's own model of the transmitter. These are:
- the recovered symbol values under injected single-sample errors;
- the exact clock edge at which lock appears after seeding and after a reseed;
- the size of the error increment;
- the realignment of a group after `data_mode` drops.

// File: rtl/prbs_link_pkg.sv
package prbs_link_pkg;

  localparam int PRBS_ORDER = 7;

  typedef logic [PRBS_ORDER-1:0] prbs_state_t;

  typedef enum logic [1:0] {
    TRK_SEED   = 2'd0,
    TRK_TRAIN  = 2'd1,
    TRK_LOCKED = 2'd2
  } trk_phase_t;

  // Feedback of x^7 + x^6 + 1; state bit 0 holds the newest bit.
  function automatic logic prbs_feedback(input prbs_state_t s);
    return s[6] ^ s[5];
  endfunction

  function automatic prbs_state_t prbs_push(input prbs_state_t s, input logic b);
    return {s[PRBS_ORDER-2:0], b};
  endfunction

endpackage

// File: rtl/prbs_tracker.sv
module prbs_tracker
  import prbs_link_pkg::*;
#(
  parameter int W          = 10,
  parameter int LOCK_WORDS = 64,
  parameter int ERR_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     rx_word,
  input  logic             data_mode,
  output logic             locked,
  output logic [ERR_W-1:0] err_count,
  output logic             demod_en,
  output logic [W-1:0]     demod_word
);

  localparam int RUN_W = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_WORDS - 1);

  trk_phase_t       phase_q;
  prbs_state_t      gen_q;
  logic [RUN_W-1:0] run_q;
  logic [ERR_W-1:0] err_q;

  logic [W-1:0] pred_word;
  prbs_state_t  gen_adv;
  prbs_state_t  seed_state;
  logic [W-1:0] mism;
  logic [CNT_W-1:0] mism_bits;

  // Named events for assertions
  logic seed_evt, check_act, miss_evt, lock_evt;

  function automatic logic [CNT_W-1:0] count_bits(input logic [W-1:0] v);
    return CNT_W'($countones(v));
  endfunction

  function automatic logic [ERR_W-1:0] sat_add(input logic [ERR_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [ERR_W:0] sum;
    sum = {1'b0, a} + (ERR_W+1)'(b);
    return sum[ERR_W] ? {ERR_W{1'b1}} : sum[ERR_W-1:0];
  endfunction

  // Predict a full word MSB first and the generator state after it
  always_comb begin
    prbs_state_t s;
    logic        b;
    s = gen_q;
    pred_word = '0;
    for (int i = W - 1; i >= 0; i--) begin
      b = prbs_feedback(s);
      pred_word[i] = b;
      s = prbs_push(s, b);
    end
    gen_adv = s;
  end

  // Seed: shift received bits in order; the last seven remain
  always_comb begin
    prbs_state_t t;
    t = '0;
    for (int i = W - 1; i >= 0; i--) t = prbs_push(t, rx_word[i]);
    seed_state = t;
  end

  assign mism      = rx_word ^ pred_word;
  assign mism_bits = count_bits(mism);
  assign seed_evt  = (phase_q == TRK_SEED);
  assign check_act = (phase_q == TRK_TRAIN) || ((phase_q == TRK_LOCKED) && !data_mode);
  assign miss_evt  = check_act && (mism != '0);
  assign lock_evt  = (phase_q == TRK_TRAIN) && (mism == '0) && (run_q == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= TRK_SEED;
      gen_q   <= '0;
      run_q   <= '0;
      err_q   <= '0;
    end else begin
      unique case (phase_q)
        TRK_SEED: begin
          gen_q   <= seed_state;
          run_q   <= '0;
          phase_q <= TRK_TRAIN;
        end
        TRK_TRAIN: begin
          if (miss_evt) begin
            gen_q <= seed_state;
            run_q <= '0;
            err_q <= sat_add(err_q, mism_bits);
          end else begin
            gen_q <= gen_adv;
            if (lock_evt) begin
              run_q   <= '0;
              phase_q <= TRK_LOCKED;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end
        end
        TRK_LOCKED: begin
          if (miss_evt) begin
            gen_q   <= seed_state;
            run_q   <= '0;
            phase_q <= TRK_TRAIN;
          end else begin
            gen_q <= gen_adv;
          end
        end
        default: phase_q <= TRK_SEED;
      endcase
    end
  end

  assign locked     = (phase_q == TRK_LOCKED);
  assign err_count  = err_q;
  assign demod_en   = locked && data_mode;
  assign demod_word = rx_word ^ pred_word;

  // R3: lock appears only after a full clean run
  a_r3_lock_after_run: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(run_q) == RUN_LAST);

  // R4: a training mismatch restarts the run
  a_r4_miss_restarts: assert property (@(posedge clk) disable iff (rst)
    miss_evt |=> run_q == '0);

  // R4: the error count never decreases
  a_r4_err_monotonic: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> err_q >= $past(err_q));

  // R5: the count stays fixed while locked
  a_r5_err_frozen: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(err_q));

  // R6: lock holds in data mode
  a_r6_lock_held: assert property (@(posedge clk) disable iff (rst)
    (locked && data_mode) |=> locked);

  // R2: the seed word is followed by training, never by lock
  a_r2_seed_then_train: assert property (@(posedge clk) disable iff (rst)
    seed_evt |=> !locked);

endmodule

// File: rtl/prbs_decim.sv
module prbs_decim #(
  parameter int W   = 10,
  parameter int OSR = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_en,
  input  logic [W-1:0] in_word,
  output logic [W-1:0] out_word,
  output logic         out_valid
);

  localparam int GW   = W * OSR;
  localparam int HW   = GW - W;
  localparam int PH_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

  logic [HW-1:0]   hist_q;
  logic [PH_W-1:0] phase_q;
  logic [GW-1:0]   grp;
  logic [W-1:0]    vote;
  logic            group_done;

  function automatic logic majority(input logic [OSR-1:0] s);
    return ($countones(s) * 2) > OSR;
  endfunction

  assign grp        = {hist_q, in_word};
  assign group_done = in_en && (phase_q == PH_LAST);

  for (genvar k = 0; k < W; k++) begin : g_vote
    assign vote[W-1-k] = majority(grp[GW-1-k*OSR -: OSR]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q    <= '0;
      phase_q   <= '0;
      out_word  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (!in_en) begin
        phase_q <= '0;
      end else begin
        hist_q <= grp[HW-1:0];
        if (group_done) begin
          phase_q   <= '0;
          out_word  <= vote;
          out_valid <= 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  // R9: a strobe follows the last word of a full group
  a_r9_valid_after_group: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_en) && $past(phase_q) == PH_LAST);

  // R9: the strobe lasts one cycle
  a_r9_valid_single: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R10: idle demodulation returns the phase to the group start
  a_r10_phase_cleared: assert property (@(posedge clk) disable iff (rst)
    !in_en |=> phase_q == '0);

endmodule

// File: rtl/prbs_link_demod.sv
module prbs_link_demod #(
  parameter int W          = 10,
  parameter int OSR        = 3,
  parameter int LOCK_WORDS = 64,
  parameter int ERR_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     rx_word,
  input  logic             data_mode,
  output logic             locked,
  output logic [ERR_W-1:0] err_count,
  output logic [W-1:0]     data_out,
  output logic             data_valid
);

  logic         demod_en;
  logic [W-1:0] demod_word;

  prbs_tracker #(
    .W(W), .LOCK_WORDS(LOCK_WORDS), .ERR_W(ERR_W)
  ) u_tracker (
    .clk(clk), .rst(rst), .rx_word(rx_word), .data_mode(data_mode),
    .locked(locked), .err_count(err_count),
    .demod_en(demod_en), .demod_word(demod_word)
  );

  prbs_decim #(
    .W(W), .OSR(OSR)
  ) u_decim (
    .clk(clk), .rst(rst), .in_en(demod_en), .in_word(demod_word),
    .out_word(data_out), .out_valid(data_valid)
  );

  // R10: no output strobe unless demodulating in the previous cycle
  a_r10_valid_needs_lock: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> $past(locked) && $past(data_mode));

endmodule

// File: tb/tb_prbs_link_demod.sv
`timescale 1ns/1ps
module tb_prbs_link_demod;

  localparam int W   = 10;
  localparam int OSR = 3;
  localparam int GW  = W * OSR;

  // {payload, per-sample flip mask}; at most one flip per symbol group
  localparam logic [W+GW-1:0] VEC [0:5] = '{
    {10'h2AA, 30'h00000000},
    {10'h155, 30'h24924924},
    {10'h3FF, 30'h12492492},
    {10'h000, 30'h09249249},
    {10'h1C3, 30'h12492492},
    {10'h0F0, 30'h00000000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  rx_word = '0;
  logic          data_mode = 1'b0;
  logic          locked;
  logic [15:0]   err_count;
  logic [W-1:0]  data_out;
  logic          data_valid;

  int n_chk  = 0;
  int n_fail = 0;
  logic [6:0] tx_h;  // tx_h[k] = bit sent k+1 positions ago

  always #10 clk = ~clk;

  prbs_link_demod dut (
    .clk(clk), .rst(rst), .rx_word(rx_word), .data_mode(data_mode),
    .locked(locked), .err_count(err_count),
    .data_out(data_out), .data_valid(data_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Transmitter model: b[n] = b[n-6] ^ b[n-7]
  function automatic logic [W-1:0] tx_next();
    logic [W-1:0] w;
    for (int i = W - 1; i >= 0; i--) begin
      w[i] = tx_h[5] ^ tx_h[6];
      tx_h = {tx_h[5:0], w[i]};
    end
    return w;
  endfunction

  function automatic logic [GW-1:0] expand(input logic [W-1:0] p);
    logic [GW-1:0] r;
    for (int k = 0; k < W; k++)
      for (int j = 0; j < OSR; j++) r[GW-1-k*OSR-j] = p[W-1-k];
    return r;
  endfunction

  task automatic step(input logic [W-1:0] w);
    rx_word = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    data_mode = 1'b0;
    rx_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 locked in reset", locked, 0);
    check("R1 err in reset", err_count, 0);
    check("R1 valid in reset", data_valid, 0);
    rst = 1'b0;
    tx_h = 7'h5A;
  endtask

  // Send n clean PRBS words, return number of data_valid strobes seen
  task automatic clean_words(input int n, output int strobes);
    strobes = 0;
    for (int i = 0; i < n; i++) begin
      step(tx_next());
      if (data_valid) strobes++;
    end
  endtask

  task automatic send_group(input logic [W-1:0] payload, input logic [GW-1:0] flips,
                            input string tag);
    logic [GW-1:0] line;
    line = expand(payload) ^ flips;
    for (int j = 0; j < OSR; j++) begin
      step(line[GW-1-j*W -: W] ^ tx_next());
      if (j < OSR - 1) check({tag, " no strobe mid-group"}, data_valid, 0);
    end
    check({tag, " strobe"}, data_valid, 1);
    check({tag, " data"}, data_out, payload);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s;
    do_reset();
    check("R1 locked after reset", locked, 0);

    // Training with data_mode already high (R10: no demodulation before lock)
    data_mode = 1'b1;
    step(tx_next());                 // seed word
    check("R2 seed counts no errors", err_count, 0);
    clean_words(63, s);
    check("R3 not locked after 63", locked, 0);
    check("R10 no strobes before lock", s, 0);
    clean_words(1, s);
    check("R3 locked after 64", locked, 1);
    check("R2 no errors in training", err_count, 0);

    // Table walk: R8 demodulation and R9 majority decimation
    for (int v = 0; v < 6; v++)
      send_group(VEC[v][W+GW-1:GW], VEC[v][GW-1:0], "R8 R9 table");

    // R6: garbage on the line in data mode keeps lock; R5 count frozen
    for (int i = 0; i < OSR; i++) begin
      void'(tx_next());
      step('0);
      check("R6 lock held on garbage", locked, 1);
    end
    check("R5 err frozen in data mode", err_count, 0);

    // R10: a checking cycle mid-group restarts the group
    step(expand(10'h3C3)[GW-1 -: W] ^ tx_next());
    data_mode = 1'b0;
    step(tx_next());
    check("R10 no strobe when checking", data_valid, 0);
    check("R7 clean word keeps lock", locked, 1);
    data_mode = 1'b1;
    send_group(10'h2D5, '0, "R10 realigned");

    // R7: mismatch while checking drops lock; R5 no count for it
    data_mode = 1'b0;
    step(tx_next() ^ 10'h380);
    check("R7 lock dropped", locked, 0);
    check("R5 err unchanged on drop", err_count, 0);
    clean_words(63, s);
    check("R7 retraining not locked at 63", locked, 0);
    clean_words(1, s);
    check("R7 relocked at 64", locked, 1);

    // R4: training mismatch counts bits and restarts the run
    do_reset();
    step(tx_next());
    clean_words(10, s);
    step(tx_next() ^ 10'h380);
    check("R4 err adds 3", err_count, 3);
    check("R4 not locked", locked, 0);
    clean_words(63, s);
    check("R4 run restarted, 63 clean", locked, 0);
    clean_words(1, s);
    check("R4 locked after restart", locked, 1);
    check("R4 err kept", err_count, 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule